// File: doc/BRIEF.md
# Dynamic 16-bit Bus Sizing Splitter

This block sits between a core that issues 32-bit bus requests and an external bus whose width is chosen per cycle. The core hands over an address, a direction, four byte enables and write data. The block runs a bus cycle and drives, besides the byte enables, the word-select (`bus_a1`) and the high-byte and low-byte strobes (`bus_bhe`, `bus_ble`) that a 16-bit device decodes. The external side ends each bus cycle with `bus_ready`. In that same clock it states the width with `bus_size16`: low means a 32-bit device, high means a 16-bit device.

When a 16-bit device answers and the request enables bytes in both halves of the word, the block runs a second bus cycle for the upper half. In that cycle the upper bytes travel on data lines 15..0. For reads, the block keeps the low half from the first cycle and joins it with the upper half from the second cycle, then returns one 32-bit result. For writes, the upper half of the write data is copied onto both halves of the bus. All control signals are active high, and read and write data use separate vectors.

The controller has three states. `ST_IDLE` waits for work. `ST_FIRST` holds the first (or only) bus cycle. `ST_SECOND` holds the extra upper-half cycle. The transitions are:
- T_ACCEPT (`ST_IDLE` to `ST_FIRST`, when `req_valid` is high).
- T_WAIT (stay in `ST_FIRST` or `ST_SECOND` while `bus_ready` is low).
- T_SPLIT (`ST_FIRST` to `ST_SECOND`, on `bus_ready` with `bus_size16` high and both halves enabled).
- T_DONE_ONE (`ST_FIRST` to `ST_IDLE`, on any other `bus_ready`).
- T_DONE_TWO (`ST_SECOND` to `ST_IDLE`, on `bus_ready`).

Top module: `szs_bus_splitter`

## Requirements
- R1: After reset the block is idle: `req_ready`=1, and `bus_cyc`, `bus_ads` and `rsp_valid` are 0.
- R2: A request accepted while `req_ready`=1 starts a bus cycle on the next clock. `bus_ads` is 1 for that first clock only. `bus_addr` and `bus_write` carry the request, and `bus_be` carries the request's enables.
- R3: While `bus_ready` is 0, the cycle continues with `bus_ads`=0 and with address, direction, byte enables and strobes unchanged. `bus_size16` has no effect in those clocks.
- R4: `rsp_rdata` bytes whose request enable (`req_be[i]` for byte i, bits 8i+7..8i) was 0 read as zero. With `bus_size16`=0 at the ending `bus_ready`, a single cycle completes and each enabled byte comes from the same lanes of `bus_rdata`.
- R5: `bus_a1`=1 exactly when `bus_be[0]` and `bus_be[1]` are both 0. `bus_bhe` = `bus_be[1]`, or `bus_be[3]` when `bus_a1`=1. `bus_ble` = `bus_be[0]`, or `bus_be[2]` when `bus_a1`=1.
- R6: If `bus_size16`=1 at the first cycle's `bus_ready`, and `req_be[1:0]` and `req_be[3:2]` are both nonzero, a second cycle follows on the next clock. It has `bus_ads`=1 and `bus_be` = request enables AND 4'b1100.
- R7: On a split read, `rsp_rdata[15:0]` comes from `bus_rdata[15:0]` of the first cycle and `rsp_rdata[31:16]` comes from `bus_rdata[15:0]` of the second cycle, masked per R4.
- R8: A request with `req_be[1:0]`=0 runs one cycle with `bus_a1`=1. If `bus_size16`=1 when it ends, `rsp_rdata[31:16]` is taken from `bus_rdata[15:0]`.
- R9: In any bus cycle with `bus_a1`=1, `bus_wdata` is `{wdata[31:16], wdata[31:16]}`. Otherwise it is the request write data unchanged.
- R10: `bus_size16` during the second cycle is ignored. That cycle always ends the transfer on its `bus_ready`.
- R11: `rsp_valid` pulses for one clock, one clock after the final `bus_ready`. `req_ready` is 0 from acceptance until that pulse.
- R12: A request with `req_be[3:2]`=0 runs one cycle for either bus width, with no second cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Core presents a request |
| req_ready | output | 1 | Block can accept a request (idle) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Word address (bits above the byte lanes) |
| req_be | input | 4 | Byte enables, bit i = byte lane i |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | One-clock pulse: transfer complete |
| rsp_rdata | output | 32 | Assembled read data |
| bus_cyc | output | 1 | A bus cycle is in progress |
| bus_ads | output | 1 | First clock of a bus cycle |
| bus_write | output | 1 | Direction of the bus cycle |
| bus_addr | output | AW | Word address of the bus cycle |
| bus_be | output | 4 | Byte enables of the bus cycle |
| bus_a1 | output | 1 | Half-word select for a 16-bit device |
| bus_bhe | output | 1 | High-byte strobe for a 16-bit device |
| bus_ble | output | 1 | Low-byte strobe for a 16-bit device |
| bus_wdata | output | 32 | Bus write data after lane steering |
| bus_rdata | input | 32 | Bus read data |
| bus_ready | input | 1 | Ends the current bus cycle |
| bus_size16 | input | 1 | Sampled with bus_ready: 1 = 16-bit device |

## Verification
The hardest case to reach is a split transfer that also has wait states in both halves. In the same run, `bus_size16` must toggle during the waits and again during the second cycle, because the block has to ignore it in all of those clocks. The bench's bus responder draws a random wait count for each half and a random width value for every non-ending clock. Directed transfers cover enable patterns that touch both halves through the middle bytes only (4'b0110), the upper half only, and the lower half only.

// File: rtl/szs_pkg.sv
`timescale 1ns/1ps
package szs_pkg;
    localparam int DW  = 32;
    localparam int HW  = DW / 2;
    localparam int BEW = DW / 8;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_FIRST  = 2'd1,
        ST_SECOND = 2'd2
    } szs_state_e;

    typedef enum logic [1:0] {
        ASM_DIRECT = 2'd0,
        ASM_SWAP   = 2'd1,
        ASM_JOIN   = 2'd2
    } szs_asm_e;
endpackage

// File: rtl/szs_ctrl.sv
`timescale 1ns/1ps
module szs_ctrl
    import szs_pkg::*;
#(
    parameter int AW = 30
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           req_valid,
    input  logic           req_write,
    input  logic [AW-1:0]  req_addr,
    input  logic [BEW-1:0] req_be,
    input  logic [DW-1:0]  req_wdata,
    input  logic           bus_ready,
    input  logic           bus_size16,
    output logic           req_ready,
    output logic           cyc,
    output logic           ads,
    output logic           write_q,
    output logic [AW-1:0]  addr_q,
    output logic [BEW-1:0] be_q,
    output logic [DW-1:0]  wdata_q,
    output logic           hi_cyc,
    output logic           cap_low,
    output logic           fin,
    output szs_asm_e       asm_mode
);
    szs_state_e state, nxt;
    logic       ads_q;
    logic       lo_any, hi_any, split;

    assign lo_any = |be_q[BEW/2-1:0];
    assign hi_any = |be_q[BEW-1:BEW/2];
    assign split  = bus_size16 && lo_any && hi_any;

    // next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:   if (req_valid) nxt = ST_FIRST;
            ST_FIRST:  if (bus_ready) nxt = split ? ST_SECOND : ST_IDLE;
            ST_SECOND: if (bus_ready) nxt = ST_IDLE;
            default:   nxt = ST_IDLE;
        endcase
    end

    // state register and request capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            ads_q   <= 1'b0;
            write_q <= 1'b0;
            addr_q  <= '0;
            be_q    <= '0;
            wdata_q <= '0;
        end else begin
            state <= nxt;
            ads_q <= (state == ST_IDLE && nxt == ST_FIRST) ||
                     (state == ST_FIRST && nxt == ST_SECOND);
            if (state == ST_IDLE && req_valid) begin
                write_q <= req_write;
                addr_q  <= req_addr;
                be_q    <= req_be;
                wdata_q <= req_wdata;
            end
        end
    end

    // outputs
    always_comb begin
        req_ready = 1'b0;
        cyc       = 1'b0;
        hi_cyc    = 1'b0;
        cap_low   = 1'b0;
        fin       = 1'b0;
        asm_mode  = ASM_DIRECT;
        unique case (state)
            ST_IDLE: req_ready = 1'b1;
            ST_FIRST: begin
                cyc      = 1'b1;
                hi_cyc   = !lo_any;
                cap_low  = bus_ready && split;
                fin      = bus_ready && !split;
                asm_mode = (bus_size16 && !lo_any) ? ASM_SWAP : ASM_DIRECT;
            end
            ST_SECOND: begin
                cyc      = 1'b1;
                hi_cyc   = 1'b1;
                fin      = bus_ready;
                asm_mode = ASM_JOIN;
            end
            default: req_ready = 1'b0;
        endcase
    end

    assign ads = ads_q;

    // R3
    wait_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc && !bus_ready) |=> ($stable(state) && $stable(be_q) && $stable(addr_q) && !ads_q));

    // R6
    split_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FIRST && bus_ready && bus_size16 && lo_any && hi_any)
            |=> (state == ST_SECOND && ads_q));

    // R10
    second_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SECOND && bus_ready) |=> (state == ST_IDLE));
endmodule

// File: rtl/szs_lane_map.sv
`timescale 1ns/1ps
module szs_lane_map
    import szs_pkg::*;
(
    input  logic [BEW-1:0] be_q,
    input  logic           hi_cyc,
    input  logic [DW-1:0]  wdata_q,
    output logic [BEW-1:0] bus_be,
    output logic           a1,
    output logic           bhe,
    output logic           ble,
    output logic [DW-1:0]  bus_wdata
);
    localparam logic [BEW-1:0] HI_MASK = {{(BEW/2){1'b1}}, {(BEW/2){1'b0}}};

    always_comb begin
        bus_be    = hi_cyc ? (be_q & HI_MASK) : be_q;
        a1        = !(bus_be[0] || bus_be[1]);
        bhe       = bus_be[1] || (a1 && bus_be[3]);
        ble       = bus_be[0] || (a1 && bus_be[2]);
        bus_wdata = a1 ? {wdata_q[DW-1:HW], wdata_q[DW-1:HW]} : wdata_q;
    end
endmodule

// File: rtl/szs_rd_assemble.sv
`timescale 1ns/1ps
module szs_rd_assemble
    import szs_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cap_low,
    input  logic           fin,
    input  szs_asm_e       asm_mode,
    input  logic [BEW-1:0] be_q,
    input  logic [DW-1:0]  bus_rdata,
    output logic           rsp_valid,
    output logic [DW-1:0]  rsp_rdata
);
    logic [HW-1:0] low_q;
    logic [DW-1:0] merged, masked;

    always_comb begin
        unique case (asm_mode)
            ASM_SWAP: merged = {bus_rdata[HW-1:0], bus_rdata[HW-1:0]};
            ASM_JOIN: merged = {bus_rdata[HW-1:0], low_q};
            default:  merged = bus_rdata;
        endcase
    end

    for (genvar b = 0; b < BEW; b++) begin : g_byte
        assign masked[8*b +: 8] = be_q[b] ? merged[8*b +: 8] : 8'h00;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            low_q     <= '0;
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= fin;
            if (cap_low) low_q <= bus_rdata[HW-1:0];
            if (fin) rsp_rdata <= masked;
        end
    end

    // R11
    rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);
endmodule

// File: rtl/szs_bus_splitter.sv
`timescale 1ns/1ps
module szs_bus_splitter
    import szs_pkg::*;
#(
    parameter int AW = 30
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic          req_write,
    input  logic [AW-1:0] req_addr,
    input  logic [3:0]    req_be,
    input  logic [31:0]   req_wdata,
    output logic          rsp_valid,
    output logic [31:0]   rsp_rdata,
    output logic          bus_cyc,
    output logic          bus_ads,
    output logic          bus_write,
    output logic [AW-1:0] bus_addr,
    output logic [3:0]    bus_be,
    output logic          bus_a1,
    output logic          bus_bhe,
    output logic          bus_ble,
    output logic [31:0]   bus_wdata,
    input  logic [31:0]   bus_rdata,
    input  logic          bus_ready,
    input  logic          bus_size16
);
    logic [BEW-1:0] be_q;
    logic [DW-1:0]  wdata_q;
    logic           hi_cyc, cap_low, fin;
    szs_asm_e       asm_mode;

    szs_ctrl #(.AW(AW)) ctrl_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_be(req_be), .req_wdata(req_wdata),
        .bus_ready(bus_ready), .bus_size16(bus_size16),
        .req_ready(req_ready), .cyc(bus_cyc), .ads(bus_ads),
        .write_q(bus_write), .addr_q(bus_addr), .be_q(be_q), .wdata_q(wdata_q),
        .hi_cyc(hi_cyc), .cap_low(cap_low), .fin(fin), .asm_mode(asm_mode)
    );

    szs_lane_map lane_i (
        .be_q(be_q), .hi_cyc(hi_cyc), .wdata_q(wdata_q),
        .bus_be(bus_be), .a1(bus_a1), .bhe(bus_bhe), .ble(bus_ble),
        .bus_wdata(bus_wdata)
    );

    szs_rd_assemble asm_i (
        .clk(clk), .rst_n(rst_n),
        .cap_low(cap_low), .fin(fin), .asm_mode(asm_mode), .be_q(be_q),
        .bus_rdata(bus_rdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
    );

    // R2
    ads_in_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ads |-> bus_cyc);

    // R5
    a1_low_lanes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cyc && bus_a1) |-> (bus_be[1:0] == 2'b00));

    // R9
    wdata_dup_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cyc && bus_a1 && bus_write) |-> (bus_wdata[31:16] == bus_wdata[15:0]));
endmodule

// File: tb/szs_bus_splitter_tb.sv
`timescale 1ns/1ps
module szs_bus_splitter_tb_top;
    localparam int AW = 30;
    localparam real HALF = 4.0;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0, req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [3:0]    req_be = '0;
    logic [31:0]   req_wdata = '0;
    logic          req_ready, rsp_valid;
    logic [31:0]   rsp_rdata;
    logic          bus_cyc, bus_ads, bus_write, bus_a1, bus_bhe, bus_ble;
    logic [AW-1:0] bus_addr;
    logic [3:0]    bus_be;
    logic [31:0]   bus_wdata;
    logic [31:0]   bus_rdata = '0;
    logic          bus_ready = 1'b0, bus_size16 = 1'b0;

    int n_vec = 0, n_bad = 0;
    bit done = 0;

    always #(HALF) clk = ~clk;

    szs_bus_splitter #(.AW(AW)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_be(req_be), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .bus_cyc(bus_cyc), .bus_ads(bus_ads), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_be(bus_be), .bus_a1(bus_a1),
        .bus_bhe(bus_bhe), .bus_ble(bus_ble), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_ready(bus_ready), .bus_size16(bus_size16)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] byte_mask(input logic [3:0] be);
        logic [31:0] m;
        for (int i = 0; i < 4; i++) m[8*i +: 8] = be[i] ? 8'hFF : 8'h00;
        return m;
    endfunction

    // checks the bus view of one cycle: cur_be is the expected enable set
    task automatic chk_bus(input string tag, input logic [3:0] cur_be, input logic wr,
                           input logic [AW-1:0] ad, input logic [31:0] wd);
        logic hi;
        hi = (cur_be[1:0] == 2'b00);
        chk({tag, " R2 cyc"},  32'(bus_cyc), 32'd1);
        chk({tag, " R2 addr"}, 32'(bus_addr), 32'(ad));
        chk({tag, " R2 write"}, 32'(bus_write), 32'(wr));
        chk({tag, " R6 be"},   32'(bus_be), 32'(cur_be));
        chk({tag, " R5 a1"},   32'(bus_a1), 32'(hi));
        chk({tag, " R5 bhe"},  32'(bus_bhe), 32'(hi ? cur_be[3] : cur_be[1]));
        chk({tag, " R5 ble"},  32'(bus_ble), 32'(hi ? cur_be[2] : cur_be[0]));
        if (wr) chk({tag, " R9 wdata"}, bus_wdata, hi ? {wd[31:16], wd[31:16]} : wd);
    endtask

    task automatic run_txn(input string tag, input logic wr, input logic [3:0] be,
                           input logic [31:0] wd, input logic [AW-1:0] ad,
                           input logic bs16, input int w1, input int w2);
        logic        split;
        logic [31:0] r1, r2, expd;
        logic [3:0]  be2;
        split = bs16 && (be[1:0] != 0) && (be[3:2] != 0);
        be2 = be & 4'b1100;
        r1 = $urandom; r2 = $urandom;
        @(negedge clk);
        chk({tag, " R11 ready idle"}, 32'(req_ready), 32'd1);
        req_valid = 1'b1; req_write = wr; req_be = be; req_wdata = wd; req_addr = ad;
        @(posedge clk); @(negedge clk);
        req_valid = 1'b0; req_be = $urandom; req_wdata = $urandom; req_addr = AW'($urandom);
        chk({tag, " R2 ads"}, 32'(bus_ads), 32'd1);
        chk({tag, " R11 busy"}, 32'(req_ready), 32'd0);
        chk_bus(tag, be, wr, ad, wd);
        for (int i = 0; i < w1; i++) begin
            bus_ready = 1'b0; bus_size16 = $urandom; bus_rdata = $urandom;
            @(posedge clk); @(negedge clk);
            chk({tag, " R3 no ads"}, 32'(bus_ads), 32'd0);
            chk_bus({tag, " R3 wait"}, be, wr, ad, wd);
        end
        bus_ready = 1'b1; bus_size16 = bs16; bus_rdata = r1;
        @(posedge clk); @(negedge clk);
        bus_ready = 1'b0; bus_size16 = $urandom; bus_rdata = $urandom;
        if (split) begin
            chk({tag, " R6 second ads"}, 32'(bus_ads), 32'd1);
            chk({tag, " R6 no rsp yet"}, 32'(rsp_valid), 32'd0);
            chk_bus({tag, " R6 second"}, be2, wr, ad, wd);
            for (int i = 0; i < w2; i++) begin
                bus_ready = 1'b0; bus_size16 = $urandom; bus_rdata = $urandom;
                @(posedge clk); @(negedge clk);
                chk({tag, " R3 no ads 2"}, 32'(bus_ads), 32'd0);
                chk_bus({tag, " R3 wait 2"}, be2, wr, ad, wd);
            end
            // R10: width value during the second cycle is random and must not matter
            bus_ready = 1'b1; bus_size16 = $urandom; bus_rdata = r2;
            @(posedge clk); @(negedge clk);
            bus_ready = 1'b0; bus_size16 = $urandom; bus_rdata = $urandom;
            expd = {r2[15:0], r1[15:0]} & byte_mask(be);
        end else if (bs16 && be[1:0] == 2'b00) begin
            expd = {r1[15:0], r1[15:0]} & byte_mask(be);
        end else begin
            expd = r1 & byte_mask(be);
        end
        chk({tag, " R11 rsp pulse"}, 32'(rsp_valid), 32'd1);
        chk({tag, " R12 no extra ads"}, 32'(bus_ads), 32'd0);
        chk({tag, " R11 ready back"}, 32'(req_ready), 32'd1);
        if (!wr) chk({tag, " R4/R7/R8 rdata"}, rsp_rdata, expd);
        @(posedge clk); @(negedge clk);
        chk({tag, " R11 pulse ends"}, 32'(rsp_valid), 32'd0);
        chk({tag, " R10 idle"}, 32'(bus_cyc), 32'd0);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        chk("R1 ready", 32'(req_ready), 32'd1);
        chk("R1 cyc", 32'(bus_cyc), 32'd0);
        chk("R1 ads", 32'(bus_ads), 32'd0);
        chk("R1 rsp", 32'(rsp_valid), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 idle after release", 32'(bus_cyc), 32'd0);

        run_txn("R4 wide rd",       1'b0, 4'hF, 32'h0,         30'h1234, 1'b0, 0, 0);
        run_txn("R4 wide rd wait",  1'b0, 4'h5, 32'h0,         30'h0042, 1'b0, 3, 0);
        run_txn("R7 split rd",      1'b0, 4'hF, 32'h0,         30'h2000, 1'b1, 0, 0);
        run_txn("R7 split mid",     1'b0, 4'h6, 32'h0,         30'h2004, 1'b1, 2, 3);
        run_txn("R9 split wr",      1'b1, 4'hF, 32'hA1B2C3D4,  30'h3000, 1'b1, 1, 1);
        run_txn("R8 hi only 16",    1'b0, 4'hC, 32'h0,         30'h0777, 1'b1, 0, 0);
        run_txn("R8 hi only 32",    1'b0, 4'h8, 32'h0,         30'h0778, 1'b0, 1, 0);
        run_txn("R8 hi wr",         1'b1, 4'h4, 32'h5566_7788, 30'h0779, 1'b1, 0, 0);
        run_txn("R12 lo only 16",   1'b0, 4'h3, 32'h0,         30'h0100, 1'b1, 2, 0);
        run_txn("R12 lo wr 16",     1'b1, 4'h1, 32'h1357_9BDF, 30'h0101, 1'b1, 0, 0);
        run_txn("R10 wide wr",      1'b1, 4'hF, 32'hDEAD_BEEF, 30'h3FFF_FFFF, 1'b0, 0, 0);

        for (int k = 0; k < 400; k++) begin
            run_txn("rand", 1'($urandom), 4'($urandom_range(15, 1)), $urandom,
                    AW'($urandom), 1'($urandom), $urandom_range(3, 0), $urandom_range(3, 0));
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        #(2.0 * HALF * 150000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule